// File: doc/BRIEF.md
# Dual-Clock Mode-Selected Shift Register

This block holds a small register word that is updated in one of two ways: a serial right shift or a parallel load. Each update kind has its own slow strobe input, and a mode input picks which strobe is live. The block runs on a single fast system clock. It samples both strobes and the mode on every system edge, and an update takes place when the selected strobe goes from HIGH to LOW.

The mode input gates the strobes. A mode change made while both strobes are LOW is always clean. A few mode changes made while a strobe is HIGH are also clean. All other such changes leave the register contents undefined, and the block reports them on a one-cycle flag. Register bit 0 is the serial entry end. A shift moves every bit one place toward the top index.

Top module: `mode_clk_shreg`

## Requirements
- R1: A synchronous active-high reset clears `q_o` to all zeros and clears `undef_o`, and it sets the internal strobe and mode samples LOW.
- R2: With `mode_i` HIGH, a HIGH-to-LOW change of `ldclk_i` copies `par_i` into `q_o` (bit i from `par_i[i]`).
- R3: With `mode_i` LOW, a HIGH-to-LOW change of `shclk_i` shifts: `q_o[0]` takes `ser_i` and `q_o[i]` takes the old `q_o[i-1]`. The old top bit is dropped.
- R4: LOW-to-HIGH changes of either strobe never alter `q_o`.
- R5: The strobe that the mode does not select has no effect on `q_o`, whether it rises or falls.
- R6: A mode change while both strobes are LOW leaves `q_o` unchanged and keeps `undef_o` LOW.
- R7: A change of `mode_i` from LOW to HIGH while `ldclk_i` is HIGH leaves `q_o` unchanged and keeps `undef_o` LOW.
- R8: A change of `mode_i` from HIGH to LOW while `shclk_i` is HIGH and `ldclk_i` is LOW leaves `q_o` unchanged and keeps `undef_o` LOW.
- R9: Any other mode change made while either strobe is HIGH raises `undef_o` for exactly one system cycle. After that change, `q_o` is not specified.
- R10: The data captured is the data present when the falling strobe is first sampled. Later changes of `ser_i` or `par_i` with no new falling strobe leave `q_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock. It is much faster than the strobes. |
| rst_i | input | 1 | Synchronous active-high reset. |
| mode_i | input | 1 | Mode select: HIGH selects load, LOW selects shift. |
| shclk_i | input | 1 | Shift strobe. It acts on its falling change. |
| ldclk_i | input | 1 | Load strobe. It acts on its falling change. |
| ser_i | input | 1 | Serial data entering bit 0. |
| par_i | input | WIDTH | Parallel load data. |
| q_o | output | WIDTH | Register contents. |
| undef_o | output | 1 | One-cycle pulse that marks a mode change with an undefined result. |

## Verification
The register and the flag are both due one system edge after the inputs change. A falling strobe or a mode change first sampled at edge k shows on `q_o` and `undef_o` just after edge k. The bench drives every input on the falling system edge and compares on the next falling edge, so each result is read half a period after the edge that produced it. After an undefined mode change, only the flag is compared. The register is compared again only after a reset or a clean load.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   typedef enum logic [1:0] {
      MC_NONE  = 2'd0,
      MC_SAFE  = 2'd1,
      MC_UNDEF = 2'd2
   } mode_chg_e;

   // classify a mode transition from its previous/current value and strobe levels
   function automatic mode_chg_e mcs_classify(input logic prev_m,
                                              input logic cur_m,
                                              input logic sh,
                                              input logic ld);
      mode_chg_e r;
      if (prev_m == cur_m)            r = MC_NONE;
      else if (!sh && !ld)            r = MC_SAFE;
      else if (cur_m && ld)           r = MC_SAFE;
      else if (!cur_m && sh && !ld)   r = MC_SAFE;
      else                            r = MC_UNDEF;
      return r;
   endfunction

endpackage

// File: rtl/mcs_clk_sel.sv
module mcs_clk_sel (
   input  logic clk_i,
   input  logic rst_i,
   input  logic mode_i,
   input  logic shclk_i,
   input  logic ldclk_i,
   output logic fall_o
);
   logic eff_now;
   logic eff_q;

   assign eff_now = mode_i ? ldclk_i : shclk_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) eff_q <= 1'b0;
      else       eff_q <= eff_now;
   end

   assign fall_o = eff_q & ~eff_now;
endmodule

// File: rtl/mcs_mode_watch.sv
module mcs_mode_watch
   import mcs_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic mode_i,
   input  logic shclk_i,
   input  logic ldclk_i,
   output logic undef_o
);
   logic      mode_q;
   logic      undef_q;
   mode_chg_e chg;

   assign chg = mcs_classify(mode_q, mode_i, shclk_i, ldclk_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mode_q  <= 1'b0;
         undef_q <= 1'b0;
      end else begin
         mode_q  <= mode_i;
         undef_q <= (chg == MC_UNDEF);
      end
   end

   assign undef_o = undef_q;
endmodule

// File: rtl/mcs_datapath.sv
module mcs_datapath #(
   parameter int WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             upd_i,
   input  logic             mode_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] nxt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_head
         assign nxt[i] = mode_i ? par_i[i] : ser_i;
      end else begin : g_body
         assign nxt[i] = mode_i ? par_i[i] : q_r[i-1];
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)      q_r <= '0;
      else if (upd_i) q_r <= nxt;
   end

   assign q_o = q_r;
endmodule

// File: rtl/mode_clk_shreg.sv
module mode_clk_shreg #(
   parameter int WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             mode_i,
   input  logic             shclk_i,
   input  logic             ldclk_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] q_o,
   output logic             undef_o
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("mode_clk_shreg: WIDTH must be at least 2");
   end

   logic fall;

   mcs_clk_sel u_sel (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .mode_i  (mode_i),
      .shclk_i (shclk_i),
      .ldclk_i (ldclk_i),
      .fall_o  (fall)
   );

   mcs_mode_watch u_watch (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .mode_i  (mode_i),
      .shclk_i (shclk_i),
      .ldclk_i (ldclk_i),
      .undef_o (undef_o)
   );

   mcs_datapath #(.WIDTH(LAST + 1)) u_dp (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .upd_i  (fall),
      .mode_i (mode_i),
      .ser_i  (ser_i),
      .par_i  (par_i),
      .q_o    (q_o)
   );
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
   parameter int WIDTH = 4
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             mode_i,
   input logic             shclk_i,
   input logic             ldclk_i,
   input logic             ser_i,
   input logic [WIDTH-1:0] par_i,
   input logic [WIDTH-1:0] q_o,
   input logic             undef_o
);
   // R1
   a_r1_reset_clear: assert property (@(posedge clk_i)
      rst_i |=> (q_o == '0) && !undef_o);

   // R2
   a_r2_load: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i && $past(mode_i) && $fell(ldclk_i)) |=> (q_o == $past(par_i)));

   // R3
   a_r3_shift: assert property (@(posedge clk_i) disable iff (rst_i)
      (!mode_i && !$past(mode_i) && $fell(shclk_i))
      |=> (q_o == {$past(q_o[WIDTH-2:0]), $past(ser_i)}));

   // R4 and R5: with mode steady, only a falling selected strobe may move q
   a_r5_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      ($stable(mode_i) && !(mode_i ? $fell(ldclk_i) : $fell(shclk_i)))
      |=> $stable(q_o));

   // R6
   a_r6_clean_change: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$stable(mode_i) && !shclk_i && !ldclk_i) |=> ($stable(q_o) && !undef_o));

   // R7
   a_r7_rise_ld_high: assert property (@(posedge clk_i) disable iff (rst_i)
      ($rose(mode_i) && ldclk_i) |=> ($stable(q_o) && !undef_o));

   // R8
   a_r8_fall_sh_high: assert property (@(posedge clk_i) disable iff (rst_i)
      ($fell(mode_i) && shclk_i && !ldclk_i) |=> ($stable(q_o) && !undef_o));

   // R9
   a_r9_flag: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$stable(mode_i) && (shclk_i || ldclk_i)
       && !($rose(mode_i) && ldclk_i)
       && !($fell(mode_i) && shclk_i && !ldclk_i)) |=> undef_o);

   // R9: no flag without a mode change
   a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
      $stable(mode_i) |=> !undef_o);
endmodule

bind mode_clk_shreg mcs_checker #(.WIDTH(WIDTH)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .mode_i  (mode_i),
   .shclk_i (shclk_i),
   .ldclk_i (ldclk_i),
   .ser_i   (ser_i),
   .par_i   (par_i),
   .q_o     (q_o),
   .undef_o (undef_o)
);

// File: tb/mode_clk_shreg_tb_top.sv
module mode_clk_shreg_tb_top;
   localparam int W = 4;
   localparam int NV = 25;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         mode = 1'b0, shc = 1'b0, ldc = 1'b0, ser = 1'b0;
   logic [W-1:0] par = '0;
   logic [W-1:0] q;
   logic         undef;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   mode_clk_shreg #(.WIDTH(W)) dut_i (
      .clk_i(clk), .rst_i(rst), .mode_i(mode), .shclk_i(shc), .ldclk_i(ldc),
      .ser_i(ser), .par_i(par), .q_o(q), .undef_o(undef)
   );

   // {mode, shclk, ldclk, ser, par[3:0], exp_q[3:0], exp_undef, check_q, req[3:0]}
   localparam logic [17:0] VEC [NV] = '{
      18'b1_0_0_0_1010_0000_0_1_0110, // R6 change with both strobes low
      18'b1_0_1_0_1010_0000_0_1_0100, // R4 load strobe rises
      18'b1_0_0_0_1010_1010_0_1_0010, // R2 load
      18'b1_0_0_0_0101_1010_0_1_1010, // R10 data moves, no edge
      18'b1_1_0_0_0101_1010_0_1_0101, // R5 shift strobe rises, deselected
      18'b1_0_0_0_0101_1010_0_1_0101, // R5 shift strobe falls, deselected
      18'b1_0_1_0_0011_1010_0_1_0100, // R4
      18'b1_0_0_0_0011_0011_0_1_0010, // R2
      18'b0_0_0_0_0011_0011_0_1_0110, // R6
      18'b0_1_0_1_0011_0011_0_1_0100, // R4
      18'b0_0_0_1_0011_0111_0_1_0011, // R3 shift in 1
      18'b0_1_0_0_0011_0111_0_1_0100, // R4
      18'b0_0_0_0_0011_1110_0_1_0011, // R3 shift in 0
      18'b0_0_0_1_0011_1110_0_1_1010, // R10 serial moves, no edge
      18'b0_0_1_0_0011_1110_0_1_0101, // R5
      18'b0_0_0_0_0011_1110_0_1_0101, // R5
      18'b0_0_1_0_0000_1110_0_1_0101, // R5
      18'b1_0_1_0_0000_1110_0_1_0111, // R7 LOW->HIGH, load strobe high
      18'b1_0_0_0_0000_0000_0_1_0010, // R2
      18'b1_1_0_0_0000_0000_0_1_0101, // R5
      18'b0_1_0_1_0000_0000_0_1_1000, // R8 HIGH->LOW, shift high, load low
      18'b0_0_0_1_0000_0001_0_1_0011, // R3
      18'b0_1_0_0_0000_0001_0_1_0100, // R4
      18'b1_1_0_0_0000_0000_1_0_1001, // R9 undefined change
      18'b1_0_0_0_0000_0000_0_0_1001  // R9 flag lasts one cycle
   };

   task automatic drive(input logic m, input logic s, input logic l,
                        input logic d, input logic [W-1:0] p);
      mode = m; shc = s; ldc = l; ser = d; par = p;
      @(negedge clk);
   endtask

   task automatic chk_q(input string req, input logic [W-1:0] exp);
      n_chk++;
      if (q !== exp) begin
         n_bad++;
         $display("FAIL %s q: actual %b expected %b", req, q, exp);
      end
   endtask

   task automatic chk_u(input string req, input logic exp);
      n_chk++;
      if (undef !== exp) begin
         n_bad++;
         $display("FAIL %s undef: actual %b expected %b", req, undef, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_q("R1", '0);
      chk_u("R1", 1'b0);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         logic [17:0] v;
         string tag;
         v = VEC[i];
         drive(v[17], v[16], v[15], v[14], v[13:10]);
         tag = $sformatf("R%0d vec%0d", v[3:0], i);
         if (v[4]) chk_q(tag, v[9:6]);
         chk_u(tag, v[5]);
      end

      // R1: reset after an undefined change
      rst = 1'b1;
      drive(1'b0, 1'b0, 1'b0, 1'b0, 4'b0000);
      chk_q("R1", '0);
      chk_u("R1", 1'b0);
      rst = 1'b0;
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'b1001);   // R6 clean change
      chk_u("R6", 1'b0);
      chk_q("R6", 4'b0000);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);   // R4 rise
      chk_q("R4", 4'b0000);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 4'b1001);   // R9 HIGH->LOW with load high
      chk_u("R9", 1'b1);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 4'b1001);
      chk_u("R9", 1'b0);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 4'b1111);   // R7 back to load, strobe high
      chk_u("R7", 1'b0);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'b1111);   // R2 clean load
      chk_q("R2", 4'b1111);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'b0110);   // R10
      chk_q("R10", 4'b1111);
      rst = 1'b1;
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'b0110);
      chk_q("R1", '0);
      rst = 1'b0;

      done = 1'b1;
      finish_run();
   end
endmodule